// File: doc/BRIEF.md
# Fault Status and Alert Register

This block keeps the fault bookkeeping for a power-path controller. It holds three eight-bit views. The first is a status view that follows the live condition flags. The second is a fault view of sticky bits that latch on the rising edge of each condition. The third is an alert mask that chooses which fault bits may pull the shared active-low alert line. A bus slave in front of the block supplies the register write strobes and a pulse when an alert response has been served or the device has been addressed. The surrounding control logic supplies the global clear events.

Condition positions in the default build follow this map. Bit 7 is the external fault input, which can be masked into an alert. Bit 6 is the general-purpose input condition, which appears in status and fault but has no mask bit. Bit 5 is the switch-short condition. Bit 4 has no live condition: it records a falling edge on the enable input. The other positions are generic conditions. An alert that has been released is not raised again by the same fault while that fault stays latched. A fresh alert needs a different masked fault bit to set, or the original bit to be cleared and then to set again.

Top module: `fault_alert_regs`

## Requirements
- R1: `status_o` equals `cond_i` as sampled at the previous clock edge, except bit 4, which always reads 0; `cond_i[4]` has no effect on any output.
- R2: A fault bit other than 4 sets in the cycle after its condition rises, and stays set after the condition falls until a clear rule removes it.
- R3: A fault write (`wr_fault_i` with `wr_data_i`) clears each fault bit written as 0, unless that bit's status bit is 1; bits written as 1 keep their value.
- R4: A falling edge on `on_i` or on `ctl_on_i`, or a high level on `lockout_i` or on `uvl_reset_i`, makes every fault bit 0 in the next cycle; this overrides every other rule.
- R5: A falling edge on `en_i` with no R4 event sets fault bit 4 and clears every other fault bit whose condition did not rise in that same cycle.
- R6: The mask resets to all zeros; a mask write (`wr_mask_i`) loads `wr_data_i`, except bit 6, which always reads 0, so fault bit 6 never raises an alert.
- R7: `alert_n_o` goes low one cycle after a fault bit becomes set while its mask bit is 1 and that bit has not already raised an alert.
- R8: A pulse on `ara_i` or on `addr_hit_i` releases `alert_n_o` high in the next cycle, unless a new alert is triggered in that same cycle.
- R9: After release, a fault bit that stays set raises no further alert, even if its condition rises again; it raises one again only after it has been cleared and has set again, and a different masked bit can raise one at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 8 | Live condition flags, one per fault position |
| en_i | input | 1 | Enable input level |
| on_i | input | 1 | On input level |
| ctl_on_i | input | 1 | Software on-control bit level |
| lockout_i | input | 1 | Internal supply lockout |
| uvl_reset_i | input | 1 | Low-threshold reset request |
| wr_fault_i | input | 1 | Fault register write strobe |
| wr_mask_i | input | 1 | Mask register write strobe |
| wr_data_i | input | 8 | Write data for either register |
| ara_i | input | 1 | Alert response served by the bus slave |
| addr_hit_i | input | 1 | Device directly addressed by the bus master |
| status_o | output | 8 | Status view |
| fault_o | output | 8 | Sticky fault view |
| mask_o | output | 8 | Alert mask view |
| alert_n_o | output | 1 | Active-low alert line |

## Verification
The bench uses the default parameters: eight flag positions, bit 4 as the enable-change record and bit 6 as the position with no mask bit. With these values both special positions are exercised next to ordinary ones. Each reset source can be tried against a fault view holding several bits. The alert re-arm memory can then be driven through every path: a continuing fault, a fault on a different bit, and a fault that is cleared and sets again.

// File: rtl/fsa_pkg.sv
// Package: shared types for the fault status and alert register.
// Assumes: all event flags are single-cycle, already synchronous to clk.
package fsa_pkg;

    // Clear events that act on the fault view as a whole
    typedef struct packed {
        logic wipe_all;   // every fault bit to zero
        logic en_drop;    // enable fell: keep only the enable-change record
    } clr_evt_t;

    localparam int unsigned DEF_FLT_W      = 8;
    localparam int unsigned DEF_ENCHG_IDX  = 4;
    localparam int unsigned DEF_NOMASK_IDX = 6;

endpackage

// File: rtl/fsa_edge_detect.sv
// Module: per-bit rising and falling edge detector.
// Assumes: inputs synchronous; the previous value resets to 0, so a level
// that is low out of reset never reports a fall.
module fsa_edge_detect #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;

        // Remember the level of the previous cycle
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig_i[i];
        end

        assign rise_o[i] = sig_i[i] & ~prev_q;
        assign fall_o[i] = prev_q & ~sig_i[i];
    end

endmodule

// File: rtl/fsa_fault_latch.sv
// Module: status view and sticky fault view.
// Each ordinary position registers its condition as status and latches a
// fault on the condition's rising edge. Position ENCHG_IDX has no live
// condition; it records an enable drop. A write of 0 clears a fault bit
// only while its status bit is 0. wipe_all beats every other rule.
module fsa_fault_latch
    import fsa_pkg::*;
#(
    parameter int unsigned FLT_W     = DEF_FLT_W,
    parameter int unsigned ENCHG_IDX = DEF_ENCHG_IDX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] cond_i,
    input  logic             wr_i,
    input  logic [FLT_W-1:0] wr_data_i,
    input  clr_evt_t         evt_i,
    output logic [FLT_W-1:0] status_o,
    output logic [FLT_W-1:0] fault_o
);

    for (genvar i = 0; i < FLT_W; i++) begin : g_pos
        if (i == ENCHG_IDX) begin : g_enchg
            logic flt_q;
            logic cond_unused;
            assign cond_unused = cond_i[i];

            // Enable-change record: set by the enable drop, cleared by a write of 0
            always_ff @(posedge clk) begin
                if (!rst_n)                       flt_q <= 1'b0;
                else if (evt_i.wipe_all)          flt_q <= 1'b0;
                else if (evt_i.en_drop)           flt_q <= 1'b1;
                else if (wr_i && !wr_data_i[i])   flt_q <= 1'b0;
            end

            assign status_o[i] = 1'b0;
            assign fault_o[i]  = flt_q;
        end else begin : g_cond
            logic stat_q, flt_q;
            logic rise, wr_clr;

            assign rise   = cond_i[i] & ~stat_q;
            assign wr_clr = wr_i & ~wr_data_i[i] & ~stat_q;

            // Track the live condition and latch its rising edge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q <= 1'b0;
                    flt_q  <= 1'b0;
                end else begin
                    stat_q <= cond_i[i];
                    if (evt_i.wipe_all)     flt_q <= 1'b0;
                    else if (evt_i.en_drop) flt_q <= rise;
                    else                    flt_q <= (flt_q & ~wr_clr) | rise;
                end
            end

            assign status_o[i] = stat_q;
            assign fault_o[i]  = flt_q;
        end
    end

    // A present condition shields its fault bit from a write of 0
    assert_clear_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !evt_i.wipe_all && !evt_i.en_drop)
        |=> ((fault_o & $past(status_o & fault_o)) == $past(status_o & fault_o)));

    // Global clear empties the fault view
    assert_wipe_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.wipe_all |=> (fault_o == '0));

    // Enable drop always leaves the enable-change record set
    assert_en_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.en_drop && !evt_i.wipe_all) |=> fault_o[ENCHG_IDX]);

    // Without any clear path, no fault bit drops
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !evt_i.wipe_all && !evt_i.en_drop)
        |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

endmodule

// File: rtl/fsa_alert_ctrl.sv
// Module: alert mask, re-arm memory and the active-low alert line.
// A masked fault bit that has not yet raised an alert triggers one; the
// re-arm memory forgets a bit once its fault bit is seen clear. Release
// comes from a served alert response or a direct address hit.
// Assumes: fault_i is the registered fault view.
module fsa_alert_ctrl
    import fsa_pkg::*;
#(
    parameter int unsigned FLT_W      = DEF_FLT_W,
    parameter int unsigned NOMASK_IDX = DEF_NOMASK_IDX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] fault_i,
    input  logic             wr_mask_i,
    input  logic [FLT_W-1:0] wr_data_i,
    input  logic             ara_i,
    input  logic             addr_hit_i,
    output logic [FLT_W-1:0] mask_o,
    output logic             alert_n_o
);

    logic [FLT_W-1:0] raised_q;
    logic [FLT_W-1:0] trig;
    logic             trig_any;
    logic             release_req;
    logic             alert_q;

    for (genvar i = 0; i < FLT_W; i++) begin : g_mask
        if (i == NOMASK_IDX) begin : g_fixed
            logic data_unused;
            assign data_unused = wr_data_i[i];
            assign mask_o[i]   = 1'b0;
        end else begin : g_reg
            logic m_q;

            // Load the mask bit on a mask write
            always_ff @(posedge clk) begin
                if (!rst_n)         m_q <= 1'b0;
                else if (wr_mask_i) m_q <= wr_data_i[i];
            end

            assign mask_o[i] = m_q;
        end
    end

    assign trig        = fault_i & mask_o & ~raised_q;
    assign trig_any    = |trig;
    assign release_req = ara_i | addr_hit_i;

    // Remember raised bits; forget a bit once its fault is clear
    always_ff @(posedge clk) begin
        if (!rst_n) raised_q <= '0;
        else        raised_q <= (raised_q | trig) & fault_i;
    end

    // Drive the alert: a new trigger wins over a release in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)           alert_q <= 1'b0;
        else if (trig_any)    alert_q <= 1'b1;
        else if (release_req) alert_q <= 1'b0;
    end

    assign alert_n_o = ~alert_q;

    // Mask comes out of reset empty
    assert_mask_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (mask_o == '0));

    // A release with nothing new pending frees the line
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && !trig_any) |=> alert_n_o);

    // The line only falls when some masked fault bit is set
    assert_alert_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n_o) |-> ((fault_i & mask_o) != '0));

endmodule

// File: rtl/fault_alert_regs.sv
// Module: fault status and alert register, top level.
// Combines edge detection of the on/enable controls, the status/fault
// views and the alert path. Assumes all inputs are synchronous to clk and
// that write and response strobes are single-cycle pulses.
module fault_alert_regs
    import fsa_pkg::*;
#(
    parameter int unsigned FLT_W      = DEF_FLT_W,
    parameter int unsigned ENCHG_IDX  = DEF_ENCHG_IDX,
    parameter int unsigned NOMASK_IDX = DEF_NOMASK_IDX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] cond_i,
    input  logic             en_i,
    input  logic             on_i,
    input  logic             ctl_on_i,
    input  logic             lockout_i,
    input  logic             uvl_reset_i,
    input  logic             wr_fault_i,
    input  logic             wr_mask_i,
    input  logic [FLT_W-1:0] wr_data_i,
    input  logic             ara_i,
    input  logic             addr_hit_i,
    output logic [FLT_W-1:0] status_o,
    output logic [FLT_W-1:0] fault_o,
    output logic [FLT_W-1:0] mask_o,
    output logic             alert_n_o
);

    localparam int unsigned CTL_N = 3;

    logic [CTL_N-1:0] ctl_rise_unused;
    logic [CTL_N-1:0] ctl_fall;
    clr_evt_t         evt;

    fsa_edge_detect #(.N(CTL_N)) u_ctl_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({ctl_on_i, on_i, en_i}),
        .rise_o (ctl_rise_unused),
        .fall_o (ctl_fall)
    );

    assign evt.wipe_all = ctl_fall[2] | ctl_fall[1] | lockout_i | uvl_reset_i;
    assign evt.en_drop  = ctl_fall[0];

    fsa_fault_latch #(
        .FLT_W     (FLT_W),
        .ENCHG_IDX (ENCHG_IDX)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .wr_i      (wr_fault_i),
        .wr_data_i (wr_data_i),
        .evt_i     (evt),
        .status_o  (status_o),
        .fault_o   (fault_o)
    );

    fsa_alert_ctrl #(
        .FLT_W      (FLT_W),
        .NOMASK_IDX (NOMASK_IDX)
    ) u_alert (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_i    (fault_o),
        .wr_mask_i  (wr_mask_i),
        .wr_data_i  (wr_data_i),
        .ara_i      (ara_i),
        .addr_hit_i (addr_hit_i),
        .mask_o     (mask_o),
        .alert_n_o  (alert_n_o)
    );

endmodule

// File: tb/test_fault_alert_regs.sv
// Directed bench: one task per scenario; inputs change after a falling
// edge and outputs are sampled at the following falling edge.
module test_fault_alert_regs;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cond_i;
    logic       en_i, on_i, ctl_on_i, lockout_i, uvl_reset_i;
    logic       wr_fault_i, wr_mask_i;
    logic [7:0] wr_data_i;
    logic       ara_i, addr_hit_i;
    logic [7:0] status_o, fault_o, mask_o;
    logic       alert_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_alert_regs i_fault_alert_regs (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .en_i(en_i), .on_i(on_i),
        .ctl_on_i(ctl_on_i), .lockout_i(lockout_i), .uvl_reset_i(uvl_reset_i),
        .wr_fault_i(wr_fault_i), .wr_mask_i(wr_mask_i), .wr_data_i(wr_data_i),
        .ara_i(ara_i), .addr_hit_i(addr_hit_i), .status_o(status_o),
        .fault_o(fault_o), .mask_o(mask_o), .alert_n_o(alert_n_o)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic make_fault(input logic [7:0] bits);
        cond_i = bits; tick();
        cond_i = 8'h00; tick();
    endtask

    task automatic write_fault(input logic [7:0] d);
        wr_fault_i = 1'b1; wr_data_i = d; tick();
        wr_fault_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 status after reset", status_o, 8'h00);
        check("R2 fault after reset", fault_o, 8'h00);
        check("R6 mask after reset", mask_o, 8'h00);
        check("R7 alert idle after reset", {7'd0, alert_n_o}, 8'h01);
    endtask

    task automatic t_sticky;
        cond_i = 8'h20; tick();
        check("R1 status follows", status_o, 8'h20);
        check("R2 fault sets on rise", fault_o, 8'h20);
        cond_i = 8'h00; tick();
        check("R2 fault sticky", fault_o, 8'h20);
        cond_i = 8'h10; tick();
        check("R1 bit4 status ignored", status_o, 8'h00);
        check("R1 bit4 fault ignored", fault_o, 8'h20);
        cond_i = 8'h00; tick();
    endtask

    task automatic t_wrclear;
        cond_i = 8'h01; tick();
        check("R2 second bit", fault_o, 8'h21);
        write_fault(8'h00);
        check("R3 present bit kept", fault_o, 8'h01);
        cond_i = 8'h00; tick();
        write_fault(8'hFF);
        check("R3 ones keep", fault_o, 8'h01);
        write_fault(8'hFE);
        check("R3 zero clears", fault_o, 8'h00);
    endtask

    task automatic t_global;
        on_i = 1'b1; ctl_on_i = 1'b1; tick();
        make_fault(8'h81);
        on_i = 1'b0; tick();
        check("R4 on fall", fault_o, 8'h00);
        make_fault(8'h22);
        ctl_on_i = 1'b0; tick();
        check("R4 ctl on fall", fault_o, 8'h00);
        make_fault(8'h0C);
        lockout_i = 1'b1; tick(); lockout_i = 1'b0;
        check("R4 lockout", fault_o, 8'h00);
        make_fault(8'h41);
        uvl_reset_i = 1'b1; tick(); uvl_reset_i = 1'b0;
        check("R4 uvl reset", fault_o, 8'h00);
    endtask

    task automatic t_enfall;
        en_i = 1'b1; tick();
        make_fault(8'h83);
        check("R2 before enable drop", fault_o, 8'h83);
        en_i = 1'b0; tick();
        check("R5 enable drop", fault_o, 8'h10);
        write_fault(8'hEF);
        check("R5 record cleared by write", fault_o, 8'h00);
    endtask

    task automatic t_alert;
        wr_mask_i = 1'b1; wr_data_i = 8'hFF; tick(); wr_mask_i = 1'b0;
        check("R6 mask bit6 fixed", mask_o, 8'hBF);
        cond_i = 8'h01; tick();
        check("R7 not yet low", {7'd0, alert_n_o}, 8'h01);
        cond_i = 8'h00; tick();
        check("R7 alert low", {7'd0, alert_n_o}, 8'h00);
        ara_i = 1'b1; tick(); ara_i = 1'b0;
        check("R8 released by response", {7'd0, alert_n_o}, 8'h01);
        make_fault(8'h01); tick();
        check("R9 continuing fault silent", {7'd0, alert_n_o}, 8'h01);
        make_fault(8'h02);
        check("R9 different bit alerts", {7'd0, alert_n_o}, 8'h00);
        addr_hit_i = 1'b1; tick(); addr_hit_i = 1'b0;
        check("R8 released by address", {7'd0, alert_n_o}, 8'h01);
        write_fault(8'hFD); tick();
        check("R3 bit1 cleared", fault_o, 8'h01);
        make_fault(8'h02);
        check("R9 recurring alerts", {7'd0, alert_n_o}, 8'h00);
        ara_i = 1'b1; tick(); ara_i = 1'b0;
        make_fault(8'h40); tick();
        check("R6 bit6 fault latched", fault_o, 8'h43);
        check("R6 bit6 no alert", {7'd0, alert_n_o}, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cond_i = 8'h00; en_i = 1'b0; on_i = 1'b0; ctl_on_i = 1'b0;
        lockout_i = 1'b0; uvl_reset_i = 1'b0; wr_fault_i = 1'b0; wr_mask_i = 1'b0;
        wr_data_i = 8'h00; ara_i = 1'b0; addr_hit_i = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sticky();
        t_wrclear();
        t_global();
        t_enfall();
        t_alert();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule